// File: doc/BRIEF.md
# Pixel Output Rounding and Clamp Stage

This block is the last arithmetic step of a video mixing pipeline. It accepts a full-precision two-input mix result and cuts it down to a smaller number of significant bits, chosen per sample from four settings. Rounding is done by adding one half of the new least significant bit and then zeroing every bit below the kept field. When that addition carries past the top of the number range, the result is held at the largest value the chosen precision can express.

Each sample travels with its own precision code and its own number format flag (unsigned or two's complement). Both flags move through the pipeline beside the data. A change of setting therefore shows up only when the first sample that entered under the new setting reaches the output. The result is held in an output register. An active-low enable input drives a bus-enable output at once, without waiting for a clock edge. The tristate pad at the chip edge uses that bus-enable output and is not part of this block.

Top module: `pix_round_clamp`

## Requirements
- R1: The precision code `prec_sel` selects how many upper bits are kept out of 13: 2'b00 keeps 8, 2'b01 keeps 10, 2'b10 keeps 12, 2'b11 keeps all 13.
- R2: When D low bits are dropped (D > 0), the result equals the input plus 2^(D-1), rounded down to a multiple of 2^D. An input of 16 with code 2'b00 gives 32; an input of 15 gives 0.
- R3: The D bits below the kept field of `dout` are always zero for the precision that the output sample was produced with. For code 2'b00 the output has the form XXXXXXXX00000.
- R4: A sample on the inputs at rising edge N appears on `dout` after rising edge N+1. Its precision code and format flag are the ones sampled with it, even when the setting changes on every cycle.
- R5: With `fmt_uns`=1 (unsigned), a rounded value that exceeds 8191 is clamped to 8191 with the dropped bits cleared. Examples: 13'h1FE0 for code 2'b00, 13'h1FFE for code 2'b10.
- R6: With `fmt_uns`=0 (two's complement), a rounded value above +4095 is clamped to +4095 with the dropped bits cleared. For code 2'b00 this gives 13'h0FE0.
- R7: In two's complement mode a negative input never saturates. -4096 (13'h1000) with code 2'b00 stays 13'h1000, and -1 (13'h1FFF) rounds to 0.
- R8: With code 2'b11, no rounding is added and `dout` equals the input sample, in either format.
- R9: `dout_oe` equals the inverse of `oe_n` at all times, including between clock edges. `oe_n` has no effect on the value stored in `dout`.
- R10: `rst` is synchronous and active high. The edge on which it is sampled high clears `dout` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mix_res | input | 13 | Full-precision mix result, unsigned or two's complement |
| prec_sel | input | 2 | Kept-bit code: 00=8, 01=10, 10=12, 11=13 |
| fmt_uns | input | 1 | 1 = unsigned sample, 0 = two's complement sample |
| oe_n | input | 1 | Active-low output enable |
| dout | output | 13 | Registered rounded and clamped result |
| dout_oe | output | 1 | Active-high bus drive enable for the pad |

## Verification
A sample driven in one cycle is captured by the input register at the next rising edge. Its rounded result is in `dout` one rising edge later. The bench drives inputs on falling edges and keeps the two most recent expected values in a two-deep queue. On each falling edge it compares `dout` with the value expected for the sample driven two falling edges earlier, which is exactly the R4 timing. `dout_oe` is combinational, so it is checked one time unit after `oe_n` changes, away from any clock edge.

// File: rtl/prc_pkg.sv
package prc_pkg;

  typedef enum logic [1:0] {
    PREC_NARROW = 2'b00,
    PREC_MID    = 2'b01,
    PREC_WIDE   = 2'b10,
    PREC_FULL   = 2'b11
  } prec_e;

  localparam int NUM_PREC = 4;

  // number of low bits dropped for a given precision code
  function automatic int drop_bits(input int code, input int w,
                                   input int ka, input int kb, input int kc);
    case (code)
      0:       return w - ka;
      1:       return w - kb;
      2:       return w - kc;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/prc_round.sv
module prc_round
  import prc_pkg::*;
#(
  parameter int W      = 13,
  parameter int KEEP_A = 8,
  parameter int KEEP_B = 10,
  parameter int KEEP_C = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] x_i,
  input  logic [1:0]   sel_i,
  input  logic         uns_i,
  output logic [W:0]   sum_q,
  output prec_e        sel_q,
  output logic         uns_q
);

  localparam int SW = W + 1;

  logic [SW-1:0] half_vec [NUM_PREC];

  for (genvar g = 0; g < NUM_PREC; g++) begin : g_half
    localparam int D = drop_bits(g, W, KEEP_A, KEEP_B, KEEP_C);
    if (D > 0) begin : g_add
      assign half_vec[g] = SW'(1) << (D - 1);
    end else begin : g_none
      assign half_vec[g] = '0;
    end
  end

  logic [SW-1:0] ext;
  logic [SW-1:0] sum_d;

  always_comb begin
    ext   = uns_i ? {1'b0, x_i} : {x_i[W-1], x_i};
    sum_d = ext + half_vec[sel_i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
      sel_q <= PREC_NARROW;
      uns_q <= 1'b0;
    end else begin
      sum_q <= sum_d;
      sel_q <= prec_e'(sel_i);
      uns_q <= uns_i;
    end
  end

  // R4
  sel_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sel_q == prec_e'($past(sel_i)));

endmodule

// File: rtl/prc_clamp.sv
module prc_clamp
  import prc_pkg::*;
#(
  parameter int W      = 13,
  parameter int KEEP_A = 8,
  parameter int KEEP_B = 10,
  parameter int KEEP_C = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W:0]   sum_i,
  input  prec_e        sel_i,
  input  logic         uns_i,
  output logic [W-1:0] dout_q,
  output prec_e        prec_q
);

  logic [W-1:0] mask_vec [NUM_PREC];
  logic [W-1:0] umax_vec [NUM_PREC];
  logic [W-1:0] smax_vec [NUM_PREC];

  for (genvar g = 0; g < NUM_PREC; g++) begin : g_lim
    localparam int D = drop_bits(g, W, KEEP_A, KEEP_B, KEEP_C);
    if (D > 0) begin : g_cut
      assign mask_vec[g] = W'((64'(1) << D) - 64'(1));
    end else begin : g_keep
      assign mask_vec[g] = '0;
    end
    assign umax_vec[g] = ~mask_vec[g];
    assign smax_vec[g] = {1'b0, {(W-1){1'b1}}} & ~mask_vec[g];
  end

  logic         ovf;
  logic [W-1:0] res_d;

  always_comb begin
    if (uns_i) ovf = sum_i[W];
    else       ovf = ~sum_i[W] & sum_i[W-1];
    if (ovf)   res_d = uns_i ? umax_vec[sel_i] : smax_vec[sel_i];
    else       res_d = sum_i[W-1:0] & ~mask_vec[sel_i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      prec_q <= PREC_NARROW;
    end else begin
      dout_q <= res_d;
      prec_q <= sel_i;
    end
  end

  // R3
  low_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (dout_q & mask_vec[prec_q]) == '0);

  // R5
  uns_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (uns_i && sum_i[W]) |=> dout_q == umax_vec[prec_q]);

  // R6
  sgn_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (!uns_i && !sum_i[W] && sum_i[W-1]) |=> dout_q == smax_vec[prec_q]);

  // R8
  full_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_i == PREC_FULL) |=> dout_q == $past(sum_i[W-1:0]));

endmodule

// File: rtl/pix_round_clamp.sv
module pix_round_clamp
  import prc_pkg::*;
#(
  parameter int W      = 13,
  parameter int KEEP_A = 8,
  parameter int KEEP_B = 10,
  parameter int KEEP_C = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] mix_res,
  input  logic [1:0]   prec_sel,
  input  logic         fmt_uns,
  input  logic         oe_n,
  output logic [W-1:0] dout,
  output logic         dout_oe
);

  logic [W:0] sum_s;
  prec_e      sel_s;
  logic       uns_s;
  prec_e      prec_out;

  prc_round #(.W(W), .KEEP_A(KEEP_A), .KEEP_B(KEEP_B), .KEEP_C(KEEP_C)) u_round (
    .clk   (clk),
    .rst   (rst),
    .x_i   (mix_res),
    .sel_i (prec_sel),
    .uns_i (fmt_uns),
    .sum_q (sum_s),
    .sel_q (sel_s),
    .uns_q (uns_s)
  );

  prc_clamp #(.W(W), .KEEP_A(KEEP_A), .KEEP_B(KEEP_B), .KEEP_C(KEEP_C)) u_clamp (
    .clk    (clk),
    .rst    (rst),
    .sum_i  (sum_s),
    .sel_i  (sel_s),
    .uns_i  (uns_s),
    .dout_q (dout),
    .prec_q (prec_out)
  );

  assign dout_oe = ~oe_n;

  // R10
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> dout == '0);

  // R9
  oe_track_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(oe_n) |-> dout_oe);

endmodule

// File: tb/pix_round_clamp_bench.sv
module pix_round_clamp_bench;

  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst;
  logic [12:0] mix_res;
  logic [1:0]  prec_sel;
  logic        fmt_uns;
  logic        oe_n;
  logic [12:0] dout;
  logic        dout_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  pix_round_clamp u_pix_round_clamp (
    .clk(clk), .rst(rst), .mix_res(mix_res), .prec_sel(prec_sel),
    .fmt_uns(fmt_uns), .oe_n(oe_n), .dout(dout), .dout_oe(dout_oe)
  );

  logic [12:0] pend_exp [2];
  logic        pend_v   [2];
  string       pend_tag [2];

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // expected result from the requirements, integer arithmetic
  function automatic logic [12:0] model(input logic [12:0] x, input logic [1:0] sel,
                                        input logic uns);
    int keep, d, step, v, r, lim;
    case (sel)
      2'b00: keep = 8;
      2'b01: keep = 10;
      2'b10: keep = 12;
      default: keep = 13;
    endcase
    d    = 13 - keep;
    step = 1 << d;
    if (uns) v = int'(x);
    else     v = (x >= 13'h1000) ? int'(x) - 8192 : int'(x);
    r = (d > 0) ? v + step / 2 : v;
    r = r & ~(step - 1);
    lim = (uns ? 8191 : 4095) & ~(step - 1);
    if (r > lim) r = lim;
    return r[12:0];
  endfunction

  task automatic step(input logic [12:0] x, input logic [1:0] sel, input logic uns,
                      input logic valid, input string tag);
    @(negedge clk);
    if (pend_v[0]) check(pend_tag[0], dout, pend_exp[0]);
    pend_exp[0] = pend_exp[1]; pend_v[0] = pend_v[1]; pend_tag[0] = pend_tag[1];
    pend_exp[1] = model(x, sel, uns); pend_v[1] = valid; pend_tag[1] = tag;
    mix_res = x; prec_sel = sel; fmt_uns = uns;
  endtask

  task automatic flush();
    step(13'h0, 2'b11, 1'b1, 1'b0, "idle");
    step(13'h0, 2'b11, 1'b1, 1'b0, "idle");
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; mix_res = 13'h0FFF; prec_sel = 2'b11; fmt_uns = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 reset clears dout", dout, 13'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 dout after release", dout, 13'h0);
  endtask

  task automatic t_modes();
    step(13'h0F0F, 2'b00, 1'b0, 1'b1, "R1 8-bit");
    step(13'h0F0F, 2'b01, 1'b0, 1'b1, "R1 10-bit");
    step(13'h0F0F, 2'b10, 1'b0, 1'b1, "R1 12-bit");
    step(13'h0F0F, 2'b11, 1'b0, 1'b1, "R1 13-bit");
    step(13'h0010, 2'b00, 1'b1, 1'b1, "R2 half rounds up");
    step(13'h000F, 2'b00, 1'b1, 1'b1, "R2 below half rounds down");
    step(13'h1234, 2'b01, 1'b1, 1'b1, "R3 low bits cleared");
    step(13'h0ABD, 2'b10, 1'b1, 1'b1, "R3 one bit cleared");
    flush();
  endtask

  task automatic t_align();
    for (int i = 0; i < 24; i++) begin
      logic [12:0] x;
      x = 13'((i * 1237 + 91) % 8192);
      step(x, 2'(i % 4), 1'((i / 4) % 2), 1'b1, "R4 per-sample precision");
    end
    flush();
  endtask

  task automatic t_sat();
    step(13'h1FFF, 2'b00, 1'b1, 1'b1, "R5 unsigned 8-bit clamp");
    step(13'h1FFF, 2'b10, 1'b1, 1'b1, "R5 unsigned 12-bit clamp");
    step(13'h0FFF, 2'b00, 1'b0, 1'b1, "R6 signed clamp max");
    step(13'h0FF0, 2'b00, 1'b0, 1'b1, "R6 signed carry clamp");
    step(13'h0FFF, 2'b01, 1'b0, 1'b1, "R6 signed 10-bit clamp");
    step(13'h1000, 2'b00, 1'b0, 1'b1, "R7 most negative kept");
    step(13'h1FFF, 2'b00, 1'b0, 1'b1, "R7 minus one to zero");
    step(13'h1FFF, 2'b11, 1'b1, 1'b1, "R8 full unsigned pass");
    step(13'h1001, 2'b11, 1'b0, 1'b1, "R8 full signed pass");
    flush();
    check("R5 model 12-bit value", model(13'h1FFF, 2'b10, 1'b1), 13'h1FFE);
  endtask

  task automatic t_oe();
    @(negedge clk);
    oe_n = 1'b1; #1;
    check("R9 drive off", {12'h0, dout_oe}, 13'h0);
    step(13'h0777, 2'b01, 1'b1, 1'b1, "R9 dout loads while disabled");
    flush();
    #(CLK_NS/4);
    oe_n = 1'b0; #1;
    check("R9 drive on between edges", {12'h0, dout_oe}, 13'h1);
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    pend_v[0] = 1'b0; pend_v[1] = 1'b0;
    pend_exp[0] = '0; pend_exp[1] = '0;
    pend_tag[0] = ""; pend_tag[1] = "";
    rst = 1'b1; mix_res = '0; prec_sel = '0; fmt_uns = 1'b0; oe_n = 1'b0;
    t_reset();
    t_modes();
    t_align();
    t_sat();
    t_oe();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule